// File: doc/BRIEF.md
# Free-Running Compare/Capture Timer

The block is a free-running up-counter with one compare channel and one capture channel. A shared prescaler turns the system clock into a count-clock enable of one cycle in four or one cycle in sixty-four. The counter steps once per enable and is never cleared by a match. When the count equals the programmed compare value, the block gives a one-cycle interrupt pulse. It can also invert a timer output pin on each match. A sticky flag records every wrap of the counter through its all-ones value, and software clears that flag with a write.

A capture input passes through a two-flop synchroniser and then an edge detector. A selected edge (rising, falling or both) copies the count into a capture register, which holds that value until the next selected edge. Software uses one address/data port for its writes, and reads back through a combinational data output. The counter width defaults to 16 bits and is a parameter.

Top module: `fr_timer`

## Requirements
- R1: After reset the counter, capture register, overflow flag, control bits, match pulse and output toggle level are all zero, and the compare register is all ones. With the output disabled, tmr_out equals port_val.
- R2: The counter increments by exactly one on each count-clock enable and holds in all other cycles. From all ones it wraps to zero. Nothing clears it except reset.
- R3: A prescaler phase counter runs freely from reset with period DIV_SLOW. Control bit 0 selects the count-clock rate. When bit 0 is 0, an enable occurs when the phase modulo DIV_FAST equals DIV_FAST-1, which is every 4th cycle by default. When bit 0 is 1, an enable occurs when the phase equals DIV_SLOW-1, which is every 64th cycle by default.
- R4: In an enable cycle where the count equals the compare value, match_irq is high for exactly the following cycle. The count still steps on that enable.
- R5: ovf_flag is set by the enable that wraps the counter from all ones to zero. Writing address 3 with data bit 0 = 1 clears the flag. If that write falls in the same cycle as a wrap, the flag stays set.
- R6: Control bits 2:1 select the capture edge: 01 rising, 10 falling, 11 both, 00 none. An edge that is not selected leaves the capture register unchanged.
- R7: On a selected edge of cap_pin, the capture register loads the count that is present in the cycle three system clocks after the pin changes. This is within 2 count clocks. The register holds that value until the next selected edge.
- R8: Control bit 3 enables the timer output. While the output is enabled, tmr_out shows a toggle level that inverts on each match, in the same cycle as the match_irq pulse. While the output is disabled, the toggle level holds and tmr_out equals port_val.
- R9: The register map is as follows. Address 0 holds the compare value (read/write). Address 1 holds the control bits 3:0 (read/write; upper bits read as zero). Address 2 holds the capture value (read only). Address 3 holds the overflow flag in bit 0 (a write of 1 clears it). Address 4 holds the live count (read only). Writes to addresses 2, 4, 5, 6 and 7 have no effect, and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data at addr |
| cap_pin | input | 1 | Asynchronous capture input |
| port_val | input | 1 | Level driven on tmr_out while the output is disabled |
| tmr_out | output | 1 | Timer output pin |
| match_irq | output | 1 | One-cycle compare-match pulse |
| ovf_flag | output | 1 | Sticky counter-wrap flag |

## Verification
The embedded properties check the following on every cycle. The count stays still between enables and steps by one on each enable. Enables never come back to back. A match pulse never lasts two cycles. The toggle level changes only alongside a match pulse. The wrap sets the flag. The capture register changes only on a selected edge. Other behaviour can be shown only by the bench's scenarios. These are the exact enable spacing of each clock setting, the cycle in which a match fires against a chosen compare value, the clear of the flag when it coincides with a wrap, and which count value a capture records for each edge selection.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;

    typedef enum logic [2:0] {
        RA_CMP  = 3'd0,
        RA_CTRL = 3'd1,
        RA_CAP  = 3'd2,
        RA_STAT = 3'd3,
        RA_CNT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic      out_en;
        edge_sel_e edge_sel;
        logic      slow_clk;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fr_timer_prescale.sv
module fr_timer_prescale #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam int FW = $clog2(DIV_FAST);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign tick = slow ? (phase == PW'(DIV_SLOW - 1))
                       : (phase[FW-1:0] == FW'(DIV_FAST - 1));

    // R3: enables are never in adjacent cycles
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/fr_timer_capture.sv
module fr_timer_capture
    import fr_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  edge_sel_e        sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap
);
    logic sync1, sync2, prev;
    logic fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign fire = edge_hit(sel, sync2 & ~prev, ~sync2 & prev);

    always_ff @(posedge clk) begin
        if (rst)       cap <= '0;
        else if (fire) cap <= cnt;
    end

    // R6: capture register holds unless a selected edge was seen
    a_r6_cap_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cap));

    // R7: a selected edge records the count of that cycle
    a_r7_cap_value: assert property (@(posedge clk) disable iff (rst)
        fire |=> cap == $past(cnt));

endmodule

// File: rtl/fr_timer_compare.sv
module fr_timer_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             out_en,
    output logic             irq,
    output logic             tog
);
    logic hit;

    assign hit = tick && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            tog <= 1'b0;
        end else begin
            irq <= hit;
            tog <= tog ^ (hit & out_en);
        end
    end

    // R4: match pulse lasts a single cycle
    a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: toggle level only moves together with a match pulse
    a_r8_tog_with_irq: assert property (@(posedge clk) disable iff (rst)
        !irq |-> $stable(tog));

endmodule

// File: rtl/fr_timer.sv
module fr_timer
    import fr_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             cap_pin,
    input  logic             port_val,
    output logic             tmr_out,
    output logic             match_irq,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_v;
    logic             ovf_q;
    logic             tick;
    logic             tog;
    logic             wrap;
    logic             clr_ovf;

    fr_timer_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
        .clk (clk),
        .rst (rst),
        .slow(ctrl_q.slow_clk),
        .tick(tick)
    );

    fr_timer_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cnt   (cnt_q),
        .cmp   (cmp_q),
        .out_en(ctrl_q.out_en),
        .irq   (match_irq),
        .tog   (tog)
    );

    fr_timer_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk),
        .rst(rst),
        .pin(cap_pin),
        .sel(ctrl_q.edge_sel),
        .cnt(cnt_q),
        .cap(cap_v)
    );

    assign wrap    = tick && (cnt_q == CNT_MAX);
    assign clr_ovf = wr_en && (addr == RA_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= CNT_MAX;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (addr == RA_CMP)  cmp_q  <= wr_data;
            if (addr == RA_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (clr_ovf) ovf_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_CMP:  rd_data = cmp_q;
            RA_CTRL: rd_data = CNT_W'(ctrl_q);
            RA_CAP:  rd_data = cap_v;
            RA_STAT: rd_data = CNT_W'(ovf_q);
            RA_CNT:  rd_data = cnt_q;
            default: rd_data = '0;
        endcase
    end

    assign tmr_out  = ctrl_q.out_en ? tog : port_val;
    assign ovf_flag = ovf_q;

    // R2: count holds between enables
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R2: count steps by one on an enable
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R5: a wrap always leaves the flag set
    a_r5_wrap_sets: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);

    // R5: the flag only rises on a wrap
    a_r5_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> !$rose(ovf_flag));

endmodule

// File: tb/fr_timer_bench.sv
`timescale 1ns/1ps
module fr_timer_bench;
    localparam int W   = 10;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         cap_pin = 1'b0;
    logic         port_val = 1'b0;
    logic         tmr_out, match_irq, ovf_flag;

    int total = 0;
    int bad   = 0;
    bit live  = 1'b0;

    fr_timer #(.CNT_W(W), .DIV_FAST(4), .DIV_SLOW(64)) u_fr_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cap_pin(cap_pin), .port_val(port_val),
        .tmr_out(tmr_out), .match_irq(match_irq), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    // expected state built from the requirements
    logic [5:0]   m_phase;
    logic [W-1:0] m_cnt, m_cmp, m_cap;
    logic [3:0]   m_ctrl;
    logic         m_ovf, m_irq, m_tog, m_p1, m_p2, m_p3;

    function automatic bit m_tick();
        return m_ctrl[0] ? (m_phase == 6'd63) : (m_phase[1:0] == 2'd3);
    endfunction

    function automatic bit m_edge();
        bit r = m_p2 & ~m_p3;
        bit f = ~m_p2 & m_p3;
        case (m_ctrl[2:1])
            2'd1: return r;
            2'd2: return f;
            2'd3: return r | f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_cmp;
            3'd1: return W'(m_ctrl);
            3'd2: return m_cap;
            3'd3: return W'(m_ovf);
            3'd4: return m_cnt;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= '0; m_cnt <= '0; m_cmp <= W'(MAX); m_cap <= '0;
            m_ctrl <= '0; m_ovf <= 1'b0; m_irq <= 1'b0; m_tog <= 1'b0;
            m_p1 <= 1'b0; m_p2 <= 1'b0; m_p3 <= 1'b0;
        end else begin
            m_phase <= m_phase + 1'b1;
            if (m_tick()) m_cnt <= m_cnt + 1'b1;
            m_irq <= m_tick() && (m_cnt == m_cmp);
            if (m_tick() && (m_cnt == m_cmp) && m_ctrl[3]) m_tog <= ~m_tog;
            if (m_tick() && (m_cnt == W'(MAX))) m_ovf <= 1'b1;
            else if (wr_en && addr == 3'd3 && wr_data[0]) m_ovf <= 1'b0;
            if (wr_en && addr == 3'd0) m_cmp <= wr_data;
            if (wr_en && addr == 3'd1) m_ctrl <= wr_data[3:0];
            m_p1 <= cap_pin; m_p2 <= m_p1; m_p3 <= m_p2;
            if (m_edge()) m_cap <= m_cnt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the expected state
    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R4 match_irq", int'(match_irq), int'(m_irq));
            chk("R8 tmr_out", int'(tmr_out), int'(m_ctrl[3] ? m_tog : port_val));
            chk("R5 ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk("R9 rd_data", int'(rd_data), int'(exp_rd(addr)));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; cap_pin = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input int exp);
        addr = a;
        #0.1;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(1_000_000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        @(negedge clk);
        do_reset();
        live = 1'b1;
        // R1 reset state
        rd(3'd4, "R1 count", 0);
        rd(3'd0, "R1 compare", MAX);
        rd(3'd1, "R1 ctrl", 0);
        rd(3'd2, "R1 capture", 0);
        chk("R1 ovf", int'(ovf_flag), 0);
        chk("R1 irq", int'(match_irq), 0);
        port_val = 1'b1; #0.1;
        chk("R1 tmr_out follows port", int'(tmr_out), 1);
        port_val = 1'b0;

        // R2/R3 fast rate: 40 edges -> 10
        cyc(40);
        rd(3'd4, "R2 R3 fast count", 10);

        // R3 slow rate: ticks at edges 64, 128
        do_reset();
        wr(3'd1, 1);          // edge 1
        cyc(126);             // edges 2..127
        rd(3'd4, "R3 slow count 127", 1);
        cyc(1);
        rd(3'd4, "R3 slow count 128", 2);

        // R4/R8 match at compare 3: tick at edge 16 sees count 3
        do_reset();
        wr(3'd0, 3);          // edge 1
        wr(3'd1, 8);          // edge 2, output on
        cyc(13);              // through edge 15
        chk("R4 no irq before match", int'(match_irq), 0);
        cyc(1);               // edge 16
        chk("R4 irq on match", int'(match_irq), 1);
        chk("R8 toggled", int'(tmr_out), 1);
        rd(3'd4, "R4 count not cleared", 4);
        cyc(1);
        chk("R4 irq single", int'(match_irq), 0);
        // next match after a full lap: count 3 again at edge 16+4*1024
        cyc(4*1024 - 1);
        chk("R8 second toggle", int'(tmr_out), 0);
        chk("R5 ovf after lap", int'(ovf_flag), 1);
        // R9 read-only addresses ignore writes
        wr(3'd4, 0);
        wr(3'd2, 5);
        rd(3'd2, "R9 capture write ignored", 0);
        wr(3'd3, 0);
        chk("R5 clear with bit0=0 ignored", int'(ovf_flag), 1);
        wr(3'd3, 1);
        chk("R5 cleared by write", int'(ovf_flag), 0);
        // R8 disabled output holds toggle, shows port
        wr(3'd1, 0);
        port_val = 1'b1; #0.1;
        chk("R8 disabled shows port", int'(tmr_out), 1);
        port_val = 1'b0;

        // R5 clear coinciding with wrap: flag stays set
        while (!(m_tick() && m_cnt == W'(MAX))) @(negedge clk);
        wr(3'd3, 1);
        chk("R5 set beats clear", int'(ovf_flag), 1);

        // R6/R7 capture edge selections
        wr(3'd1, 2);          // rising
        cyc(5);
        cap_pin = 1'b1;
        cyc(2);
        rd(3'd2, "R7 capture not yet", 0);
        begin
            logic [W-1:0] c_at;
            addr = 3'd4; #0.1; c_at = rd_data;
            cyc(1);
            rd(3'd2, "R7 rising captured", int'(c_at));
        end
        begin
            logic [W-1:0] held;
            addr = 3'd2; #0.1; held = rd_data;
            cap_pin = 1'b0;
            cyc(12);
            rd(3'd2, "R6 falling ignored in rise mode", int'(held));
            wr(3'd1, 0);      // off
            cap_pin = 1'b1; cyc(10); cap_pin = 1'b0; cyc(10);
            rd(3'd2, "R6 disabled no capture", int'(held));
        end
        wr(3'd1, 4);          // falling
        cap_pin = 1'b1; cyc(10);
        begin
            logic [W-1:0] c_at;
            cap_pin = 1'b0; cyc(2);
            addr = 3'd4; #0.1; c_at = rd_data;
            cyc(1);
            rd(3'd2, "R7 falling captured", int'(c_at));
        end
        wr(3'd1, 6);          // both
        cyc(20);
        cap_pin = 1'b1; cyc(6);
        rd(3'd2, "R6 both rising", int'(m_cap));

        // random mix checked every cycle against the expected state
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                wr_en = 1'b1;
                addr = 3'($urandom_range(0, 7));
                wr_data = W'($urandom);
            end else begin
                wr_en = 1'b0;
                addr = 3'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 15) == 0) cap_pin = ~cap_pin;
            port_val = 1'($urandom);
            @(negedge clk);
        end
        wr_en = 1'b0;
        cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule